// File: doc/BRIEF.md
# Slow-Sampled Push-Button Pulse Generator

This block turns raw mechanical push-button levels into clean, single-clock command pulses. It exists to serve a small display controller in which four direction buttons nudge an on-screen object. Each button passes through a two-flop synchronizer. After that, the button is looked at only on a shared slow tick, about 10 Hz when derived from a 100 MHz system clock. Contact bounce settles long before the next tick, so the bounce never reaches the decision logic.

Behind each synchronized button sits a three-state machine: idle, fire and wait-release. A tick that finds the button down moves the machine from idle to fire. The fire state lasts exactly one system clock and asserts the output for that clock. The machine then parks in wait-release until a later tick finds the button up. A held button therefore yields one pulse and no more. A press has to span a tick to be seen, which in the full-rate build means holding it for over 100 ms. The tick divisor is a parameter, so a simulation can run with a short period.

Top module: `btn_pulse_gen`

## Requirements
- R1: While `rst` is high every `press_pulse` bit is 0. Reset puts every state machine in idle and clears the tick divider, so the first tick falls in the clock cycle that follows the `TICK_DIV-1`th rising edge after reset is released. A button held across reset therefore gives its first pulse in the cycle after edge `TICK_DIV`.
- R2: The internal sample tick is high for exactly one clock in every `TICK_DIV` clocks, and its counter never leaves the range 0 to `TICK_DIV-1`.
- R3: A button that the synchronizer presents as pressed at a tick produces one `press_pulse` that is exactly one clock wide. The pulse appears in the clock right after the tick cycle, which is phase 0 of the next tick period when counted from reset.
- R4: While a button stays pressed, no further pulse appears on its bit, however many ticks pass. A new pulse needs a tick that sees the button released first.
- R5: A press that starts and ends between two ticks, once the two-flop synchronizer delay is counted, produces no pulse.
- R6: A button that chatters between pressed and released for several clocks and then settles pressed across a tick produces exactly one pulse.
- R7: The `NUM_BTNS` buttons are independent. Bit i of `btn_raw` affects only bit i of `press_pulse`, and simultaneous presses each give their own single pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| btn_raw | input | NUM_BTNS | Raw, unsynchronized button levels, 1 = pressed |
| press_pulse | output | NUM_BTNS | One-clock pulse per detected press, one bit per button |

## Verification
The assertions take for granted that each button level arrives as an asynchronous input. They also assume that the synchronized level is the only view of a button the state machine uses, so a pulse may begin only after a cycle in which the tick and a pressed level coincided. The stimulus keeps every change on `btn_raw` on the falling clock edge, and a reference phase counter in the bench, restarted by reset, decides exactly where each change lands against the tick. Each hold or glitch is placed so that its synchronized image either clearly spans a tick or clearly misses one, so no vector depends on a race at the sampling edge.

// File: rtl/btn_pulse_pkg.sv
package btn_pulse_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_FIRE = 2'd1,
      ST_HOLD = 2'd2
   } press_state_t;

endpackage

// File: rtl/slow_tick_gen.sv
module slow_tick_gen #(
   parameter int TICK_DIV = 10_000_000
) (
   input  logic clk,
   input  logic rst,
   output logic tick_o
);

   localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
   localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

   generate
      if (TICK_DIV < 2) begin : g_bad_div
         $error("slow_tick_gen: TICK_DIV must be at least 2");
      end
   endgenerate

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '0;
      end else if (cnt_q == LAST) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign tick_o = (cnt_q == LAST);

   // R2: tick never lasts two clocks
   assert_tick_single_R2: assert property (@(posedge clk) disable iff (rst)
      tick_o |=> !tick_o);

   // R2: divider stays inside its range
   assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (rst)
      cnt_q <= LAST);

endmodule

// File: rtl/level_sync.sv
module level_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic d_i,
   output logic q_o
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("level_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         chain_q <= '0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], d_i};
      end
   end

   assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/btn_press_fsm.sv
module btn_press_fsm
   import btn_pulse_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic tick_i,
   input  logic level_i,
   output logic pulse_o
);

   press_state_t state_q, state_d;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE: if (tick_i && level_i)  state_d = ST_FIRE;
         ST_FIRE:                         state_d = ST_HOLD;
         ST_HOLD: if (tick_i && !level_i) state_d = ST_IDLE;
         default:                         state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= ST_IDLE;
      end else begin
         state_q <= state_d;
      end
   end

   assign pulse_o = (state_q == ST_FIRE);

   // R3: a pulse is exactly one clock wide
   assert_pulse_width_R3: assert property (@(posedge clk) disable iff (rst)
      pulse_o |=> !pulse_o);

   // R3, R5: a pulse starts only after a tick saw the button pressed
   assert_pulse_cause_R3: assert property (@(posedge clk) disable iff (rst)
      $rose(pulse_o) |-> $past(tick_i && level_i));

   // R4: a button still held after its pulse gives no second pulse
   assert_no_repeat_R4: assert property (@(posedge clk) disable iff (rst)
      (pulse_o && level_i) |=> !pulse_o);

endmodule

// File: rtl/btn_pulse_gen.sv
module btn_pulse_gen #(
   parameter int NUM_BTNS    = 4,
   parameter int TICK_DIV    = 10_000_000,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst,
   input  logic [NUM_BTNS-1:0] btn_raw,
   output logic [NUM_BTNS-1:0] press_pulse
);

   generate
      if (NUM_BTNS < 1) begin : g_bad_num
         $error("btn_pulse_gen: NUM_BTNS must be at least 1");
      end
   endgenerate

   logic sample_tick;

   slow_tick_gen #(.TICK_DIV(TICK_DIV)) tick_i (
      .clk    (clk),
      .rst    (rst),
      .tick_o (sample_tick)
   );

   generate
      for (genvar b = 0; b < NUM_BTNS; b++) begin : g_btn
         logic btn_synced;

         level_sync #(.STAGES(SYNC_STAGES)) sync_i (
            .clk (clk),
            .rst (rst),
            .d_i (btn_raw[b]),
            .q_o (btn_synced)
         );

         btn_press_fsm fsm_i (
            .clk     (clk),
            .rst     (rst),
            .tick_i  (sample_tick),
            .level_i (btn_synced),
            .pulse_o (press_pulse[b])
         );
      end
   endgenerate

   logic rst_seen_q;

   always_ff @(posedge clk) begin
      rst_seen_q <= rst;
      // R1: outputs stay quiet through reset
      if (rst_seen_q) begin
         assert_reset_quiet_R1: assert (press_pulse == '0);
      end
   end

   // R7: several buttons can fire at once, but each bit is one clock wide
   assert_bits_single_R7: assert property (@(posedge clk) disable iff (rst)
      (press_pulse != '0) |=> ((press_pulse & $past(press_pulse)) == '0));

endmodule

// File: tb/btn_pulse_gen_tb.sv
module btn_pulse_gen_tb_top;

   localparam int NB  = 4;
   localparam int DIV = 8;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [NB-1:0] btn = '0;
   logic [NB-1:0] press_pulse;

   always #5 clk = ~clk;

   btn_pulse_gen #(.NUM_BTNS(NB), .TICK_DIV(DIV), .SYNC_STAGES(2)) dut_i (
      .clk         (clk),
      .rst         (rst),
      .btn_raw     (btn),
      .press_pulse (press_pulse)
   );

   // reference phase: rising edges since reset release
   int cyc = 0;
   always @(posedge clk) begin
      if (rst) cyc <= 0;
      else     cyc <= cyc + 1;
   end

   int errors = 0;
   int checks = 0;
   int pcount [NB];
   int first_cyc [NB];
   int werr;
   logic [NB-1:0] prev_p;

   typedef struct packed {
      logic [3:0] mask;
      logic       glitch;
      logic       bounce;
      logic [7:0] hold;
      logic [1:0] expn;
   } vec_t;

   localparam int NV = 6;
   localparam vec_t VECS [NV] = '{
      '{4'b0001, 1'b0, 1'b0, 8'd3,  2'd1},  // R3 plain press
      '{4'b0010, 1'b1, 1'b0, 8'd0,  2'd0},  // R5 short glitch
      '{4'b0100, 1'b0, 1'b0, 8'd10, 2'd1},  // R4 long hold
      '{4'b1000, 1'b0, 1'b1, 8'd3,  2'd1},  // R6 chatter then hold
      '{4'b1111, 1'b0, 1'b0, 8'd2,  2'd1},  // R7 all at once
      '{4'b0011, 1'b0, 1'b0, 8'd1,  2'd1}   // R3 one period exactly
   };

   task automatic check(input logic ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic clear_mon();
      for (int b = 0; b < NB; b++) begin
         pcount[b] = 0;
         first_cyc[b] = -1;
      end
      werr = 0;
   endtask

   task automatic step();
      @(negedge clk);
      for (int b = 0; b < NB; b++) begin
         if (press_pulse[b]) begin
            pcount[b]++;
            if (first_cyc[b] < 0) first_cyc[b] = cyc;
            if (prev_p[b]) werr++;
         end
      end
      prev_p = press_pulse;
   endtask

   task automatic steps(input int n);
      for (int i = 0; i < n; i++) step();
   endtask

   task automatic to_phase0();
      while ((cyc % DIV) != 0) step();
   endtask

   initial begin
      prev_p = '0;
      clear_mon();
      steps(3);
      check(press_pulse == '0, "R1 outputs low in reset", int'(press_pulse), 0);
      @(negedge clk);
      rst = 1'b0;
      step();

      for (int v = 0; v < NV; v++) begin
         to_phase0();
         clear_mon();
         if (VECS[v].glitch) begin
            btn = VECS[v].mask;
            step();
            btn = '0;
         end
         if (VECS[v].bounce) begin
            for (int k = 0; k < 4; k++) begin
               btn = (k % 2 == 0) ? VECS[v].mask : '0;
               step();
            end
         end
         if (VECS[v].hold != 0) begin
            btn = VECS[v].mask;
            steps(int'(VECS[v].hold) * DIV);
         end
         btn = '0;
         steps(3 * DIV);
         for (int b = 0; b < NB; b++) begin
            int exp_n;
            exp_n = VECS[v].mask[b] ? int'(VECS[v].expn) : 0;
            check(pcount[b] == exp_n,
                  $sformatf("R3/R4/R5/R6/R7 vec%0d btn%0d pulse count", v, b),
                  pcount[b], exp_n);
            if (exp_n > 0)
               check((first_cyc[b] % DIV) == 0,
                     $sformatf("R3 vec%0d btn%0d pulse phase", v, b),
                     first_cyc[b] % DIV, 0);
         end
         check(werr == 0, $sformatf("R3 vec%0d pulse width", v), werr, 0);
      end

      // R4 second press after release gives a fresh pulse
      to_phase0();
      clear_mon();
      btn = 4'b0001;
      steps(3 * DIV);
      btn = '0;
      steps(2 * DIV);
      btn = 4'b0001;
      steps(3 * DIV);
      btn = '0;
      steps(3 * DIV);
      check(pcount[0] == 2, "R4 release then press again", pcount[0], 2);

      // R1 reset while held: idle again, divider restarted
      to_phase0();
      clear_mon();
      btn = 4'b0100;
      steps(2 * DIV);
      check(pcount[2] == 1, "R1 pre-reset pulse", pcount[2], 1);
      @(negedge clk);
      rst = 1'b1;
      steps(3);
      check(press_pulse == '0, "R1 outputs low in mid-run reset", int'(press_pulse), 0);
      @(negedge clk);
      rst = 1'b0;
      clear_mon();
      steps(3 * DIV);
      check(pcount[2] == 1, "R1 held button fires once after reset", pcount[2], 1);
      check(first_cyc[2] == DIV, "R1 first tick after reset", first_cyc[2], DIV);
      btn = '0;
      steps(2 * DIV);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #2_000_000;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule